// File: doc/BRIEF.md
# Segmented Two-Level Address Translator

This block turns a segment-relative address into a physical address. A start strobe captures a byte offset, the base of the segment it belongs to, the directory base register and a paging enable. The offset and the segment base are added to form a 32-bit linear address. If paging is disabled, that linear address is returned unchanged and memory is never accessed.

If paging is enabled, the block performs a two-level walk through a plain request/response memory port. It first fetches a directory entry, then the table entry that the directory entry points to. It then joins the page frame from the table entry with the low twelve bits of the linear address. If either entry has its present flag clear, the walk stops early and reports a fault. Each translation ends with a one-cycle completion pulse.

The controller has four named states. IDLE waits for start. READ_DIR holds a request for the directory entry. READ_TBL holds a request for the table entry. FINISH raises the completion pulse. The transitions are as follows:
- IDLE→FINISH on start with paging off.
- IDLE→READ_DIR on start with paging on.
- READ_DIR→READ_TBL on a response with the present bit set.
- READ_DIR→FINISH on a response with the present bit clear.
- READ_TBL→FINISH on any response.
- FINISH→IDLE always.

Top module: `seg_page_walker`

## Requirements
- R1: The linear address is seg_base + seg_offset modulo 2^32. With paging off, the result is available on phys_addr.
- R2: With paging off, done is high in the cycle right after the clock edge that samples start, phys_addr equals the linear address, and mem_req never rises.
- R3: With paging on, the first request address is {dir_base[31:12], 12'h000} + 4 × linear[31:22]. The low 12 bits of dir_base have no effect.
- R4: The second request address is {dir_entry[31:12], 12'h000} + 4 × linear[21:12]. It is issued only after the first response has been accepted.
- R5: On a successful walk, phys_addr = {table_entry[31:12], linear[11:0]}, fault is low, and exactly two requests are made.
- R6: mem_req stays high with a stable mem_addr until mem_rsp_valid is seen at a clock edge.
- R7: If the directory entry has bit 0 (present) at 0, the walk ends with done and fault both high, phys_addr equal to 0, and only one request made.
- R8: If the table entry has bit 0 (present) at 0, the walk ends with done and fault both high and phys_addr equal to 0.
- R9: done is a single-cycle pulse. fault is high only while done is high, and mem_req is low while done is high.
- R10: A start strobe that arrives while a walk is in progress has no effect. The running walk finishes with its own result, and no extra done pulse follows.
- R11: After reset, done, fault and mem_req are low and phys_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a translation (sampled only in IDLE) |
| seg_offset | input | 32 | Byte offset within the segment |
| seg_base | input | 32 | Segment base address |
| dir_base | input | 32 | Directory base register; bits 31:12 used |
| paging_en | input | 1 | Enables the two-level walk |
| mem_req | output | 1 | Memory read request, held until response |
| mem_addr | output | 32 | Address of the entry being read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| phys_addr | output | 32 | Translated physical address |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended on a non-present entry (with done) |

## Verification
The bench targets several corner cases:
- **Segment add that wraps past 2^32.** A design that gets this wrong returns an address carrying bit 32.
- **Directory base with non-zero low bits.** Leaking those bits shifts the first entry address.
- **Indices at 0 and 1023, and a memory that stalls before answering.** These expose a walker that changes its address or drops its request early.
- **Non-present entries at each level, and a start pulse in the middle of a walk.** A faulty design would go on to read the table, report a stale address, or restart and emit a second done.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_READ_DIR = 2'd1,
        ST_READ_TBL = 2'd2,
        ST_FINISH   = 2'd3
    } walk_state_t;

endpackage

// File: rtl/lin_addr_unit.sv
module lin_addr_unit #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [ADDR_W-1:0] seg_offset,
    output logic [ADDR_W-1:0] lin_addr
);
    // Modular sum: the carry out of the top bit is discarded.
    always_comb begin
        lin_addr = seg_base + seg_offset;
    end
endmodule

// File: rtl/entry_addr_unit.sv
module entry_addr_unit #(
    parameter int ADDR_W      = 32,
    parameter int OFF_W       = 12,
    parameter int IDX_W       = 10,
    parameter int ENTRY_SHIFT = 2
) (
    input  logic [ADDR_W-OFF_W-1:0] frame,
    input  logic [IDX_W-1:0]        index,
    output logic [ADDR_W-1:0]       entry_addr
);
    localparam int FRAME_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] table_start;
    logic [ADDR_W-1:0] index_bytes;

    always_comb begin
        table_start = {frame, {OFF_W{1'b0}}};
        index_bytes = ADDR_W'(index) << ENTRY_SHIFT;
        entry_addr  = table_start + index_bytes;
    end
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
    import pt_walk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    paging_en,
    input  logic [ADDR_W-1:0]       lin_in,
    input  logic [ADDR_W-OFF_W-1:0] dir_frame_in,
    input  logic                    rsp_valid,
    input  logic                    rsp_present,
    input  logic [ADDR_W-OFF_W-1:0] rsp_frame,
    output walk_state_t             state,
    output logic [ADDR_W-1:0]       lin_q,
    output logic [ADDR_W-OFF_W-1:0] dir_frame_q,
    output logic [ADDR_W-OFF_W-1:0] tbl_frame_q,
    output logic [ADDR_W-1:0]       phys_q,
    output logic                    mem_req,
    output logic                    done,
    output logic                    fault
);
    localparam int FRAME_W = ADDR_W - OFF_W;

    walk_state_t state_nxt;
    logic        fault_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state decode
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nxt = paging_en ? ST_READ_DIR : ST_FINISH;
                end
            end
            ST_READ_DIR: begin
                if (rsp_valid) begin
                    state_nxt = rsp_present ? ST_READ_TBL : ST_FINISH;
                end
            end
            ST_READ_TBL: begin
                if (rsp_valid) begin
                    state_nxt = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Datapath registers captured along the walk
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lin_q       <= '0;
            dir_frame_q <= '0;
            tbl_frame_q <= '0;
            phys_q      <= '0;
            fault_q     <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        lin_q       <= lin_in;
                        dir_frame_q <= dir_frame_in;
                        fault_q     <= 1'b0;
                        phys_q      <= paging_en ? '0 : lin_in;
                    end
                end
                ST_READ_DIR: begin
                    if (rsp_valid) begin
                        if (rsp_present) begin
                            tbl_frame_q <= rsp_frame;
                        end else begin
                            fault_q <= 1'b1;
                        end
                    end
                end
                ST_READ_TBL: begin
                    if (rsp_valid) begin
                        if (rsp_present) begin
                            phys_q <= {rsp_frame, lin_q[OFF_W-1:0]};
                        end else begin
                            fault_q <= 1'b1;
                        end
                    end
                end
                ST_FINISH: begin
                    fault_q <= fault_q;
                end
                default: fault_q <= 1'b0;
            endcase
        end
    end

    // Output decode
    always_comb begin
        mem_req = (state == ST_READ_DIR) || (state == ST_READ_TBL);
        done    = (state == ST_FINISH);
        fault   = (state == ST_FINISH) && fault_q;
    end

    logic [FRAME_W-1:0] unused_width_tie;
    assign unused_width_tie = '0;
endmodule

// File: rtl/seg_page_walker.sv
module seg_page_walker
    import pt_walk_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int OFF_W       = 12,
    parameter int IDX_W       = 10,
    parameter int ENTRY_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] seg_offset,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic              paging_en,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              done,
    output logic              fault
);
    localparam int FRAME_W  = ADDR_W - OFF_W;
    localparam int TBL_LO   = OFF_W;
    localparam int DIR_LO   = OFF_W + IDX_W;

    walk_state_t        state;
    logic [ADDR_W-1:0]  lin_sum;
    logic [ADDR_W-1:0]  lin_q;
    logic [FRAME_W-1:0] dir_frame_q;
    logic [FRAME_W-1:0] tbl_frame_q;
    logic [FRAME_W-1:0] sel_frame;
    logic [IDX_W-1:0]   sel_index;
    logic [IDX_W-1:0]   dir_index;
    logic [IDX_W-1:0]   tbl_index;

    lin_addr_unit #(.ADDR_W(ADDR_W)) u_lin (
        .seg_base   (seg_base),
        .seg_offset (seg_offset),
        .lin_addr   (lin_sum)
    );

    walk_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .paging_en    (paging_en),
        .lin_in       (lin_sum),
        .dir_frame_in (dir_base[ADDR_W-1:OFF_W]),
        .rsp_valid    (mem_rsp_valid),
        .rsp_present  (mem_rsp_data[0]),
        .rsp_frame    (mem_rsp_data[ADDR_W-1:OFF_W]),
        .state        (state),
        .lin_q        (lin_q),
        .dir_frame_q  (dir_frame_q),
        .tbl_frame_q  (tbl_frame_q),
        .phys_q       (phys_addr),
        .mem_req      (mem_req),
        .done         (done),
        .fault        (fault)
    );

    // Index fields of the captured linear address
    always_comb begin
        dir_index = lin_q[DIR_LO +: IDX_W];
        tbl_index = lin_q[TBL_LO +: IDX_W];
    end

    // One address generator shared by both levels
    always_comb begin
        if (state == ST_READ_TBL) begin
            sel_frame = tbl_frame_q;
            sel_index = tbl_index;
        end else begin
            sel_frame = dir_frame_q;
            sel_index = dir_index;
        end
    end

    entry_addr_unit #(
        .ADDR_W      (ADDR_W),
        .OFF_W       (OFF_W),
        .IDX_W       (IDX_W),
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_entry (
        .frame      (sel_frame),
        .index      (sel_index),
        .entry_addr (mem_addr)
    );

    logic unused_low_bits;
    assign unused_low_bits = ^{dir_base[OFF_W-1:0], mem_rsp_data[OFF_W-1:1]};
endmodule

// File: rtl/seg_page_walker_chk.sv
module seg_page_walker_chk
    import pt_walk_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        paging_en,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_rsp_valid,
    input logic [31:0] phys_addr,
    input logic        done,
    input logic        fault,
    input walk_state_t state
);
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr)));

    assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && !paging_en) |=> (done && !mem_req));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fault_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (done && !mem_req));

    assert_fault_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (phys_addr == 32'h0));

    assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ_TBL || state == ST_FINISH) |=> (state != ST_READ_DIR));
endmodule

bind seg_page_walker seg_page_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .paging_en     (paging_en),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .phys_addr     (phys_addr),
    .done          (done),
    .fault         (fault),
    .state         (state)
);

// File: tb/seg_page_walker_tb.sv
`timescale 1ns/1ps
module seg_page_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] seg_offset = '0;
    logic [31:0] seg_base = '0;
    logic [31:0] dir_base = '0;
    logic        paging_en = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic [31:0] phys_addr;
    logic        done;
    logic        fault;

    int errors = 0;
    int checks = 0;

    logic [31:0] mem [logic [31:0]];
    int          req_count = 0;
    logic [31:0] req_log [4];
    int          rsp_delay = 0;
    int          wait_cnt = 0;
    int          done_cnt = 0;

    logic [31:0] got_phys;
    logic        got_fault;
    int          got_lat;

    always #5 clk = ~clk;

    seg_page_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .seg_offset(seg_offset),
        .seg_base(seg_base), .dir_base(dir_base), .paging_en(paging_en),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .phys_addr(phys_addr), .done(done), .fault(fault)
    );

    // Memory model: answers a held request after rsp_delay idle cycles
    always @(negedge clk) begin
        if (done) done_cnt++;
        if (mem_rsp_valid) begin
            mem_rsp_valid = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt < rsp_delay) begin
                wait_cnt++;
            end else begin
                wait_cnt = 0;
                if (req_count < 4) req_log[req_count] = mem_addr;
                req_count++;
                mem_rsp_data  = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                mem_rsp_valid = 1'b1;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish (actual hung, expected end)");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic run_walk(input logic [31:0] b, input logic [31:0] off,
                            input logic [31:0] db, input bit pg, input int dly);
        @(negedge clk);
        req_count  = 0;
        rsp_delay  = dly;
        done_cnt   = 0;
        seg_base   = b;
        seg_offset = off;
        dir_base   = db;
        paging_en  = pg;
        start      = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        got_lat = 1;
        while (!done && got_lat < 100) begin
            @(negedge clk);
            got_lat++;
        end
        got_phys  = phys_addr;
        got_fault = fault;
    endtask

    task automatic test_reset();
        chk(done == 1'b0, "R11 done", 32'(done), 32'h0);
        chk(fault == 1'b0, "R11 fault", 32'(fault), 32'h0);
        chk(mem_req == 1'b0, "R11 mem_req", 32'(mem_req), 32'h0);
        chk(phys_addr == 32'h0, "R11 phys_addr", phys_addr, 32'h0);
    endtask

    task automatic test_bypass();
        run_walk(32'h0000_3000, 32'hF000_1234, 32'h0010_0000, 1'b0, 0);
        chk(got_lat == 1, "R2 latency", 32'(got_lat), 32'd1);
        chk(got_phys == 32'hF000_4234, "R1 linear sum", got_phys, 32'hF000_4234);
        chk(req_count == 0, "R2 no reads", 32'(req_count), 32'd0);
        chk(got_fault == 1'b0, "R2 no fault", 32'(got_fault), 32'h0);
        run_walk(32'hFFFF_F000, 32'h0000_2000, 32'h0, 1'b0, 0);
        chk(got_phys == 32'h0000_1000, "R1 wrap", got_phys, 32'h0000_1000);
    endtask

    task automatic test_example_walk();
        run_walk(32'h0000_3000, 32'hF000_1234, 32'h0010_0ABC, 1'b1, 0);
        chk(req_count == 2, "R5 two reads", 32'(req_count), 32'd2);
        chk(req_log[0] == 32'h0010_0F00, "R3 dir entry addr", req_log[0], 32'h0010_0F00);
        chk(req_log[1] == 32'h0020_0010, "R4 tbl entry addr", req_log[1], 32'h0020_0010);
        chk(got_phys == 32'h0000_1234, "R5 phys", got_phys, 32'h0000_1234);
        chk(got_fault == 1'b0, "R5 fault low", 32'(got_fault), 32'h0);
        @(negedge clk);
        chk(done == 1'b0, "R9 single pulse", 32'(done), 32'h0);
        chk(done_cnt == 1, "R9 one done", 32'(done_cnt), 32'd1);
    endtask

    task automatic test_stalled_edges();
        run_walk(32'h0, 32'h003F_F567, 32'h0010_0000, 1'b1, 3);
        chk(req_log[0] == 32'h0010_0000, "R3 index 0", req_log[0], 32'h0010_0000);
        chk(req_log[1] == 32'h0050_0FFC, "R4 index 1023", req_log[1], 32'h0050_0FFC);
        chk(got_phys == 32'hABCD_E567, "R6 stalled phys", got_phys, 32'hABCD_E567);
        chk(req_count == 2, "R6 reads", 32'(req_count), 32'd2);
    endtask

    task automatic test_dir_fault();
        run_walk(32'h0, 32'h0080_0000, 32'h0010_0000, 1'b1, 1);
        chk(got_fault == 1'b1, "R7 fault", 32'(got_fault), 32'h1);
        chk(got_phys == 32'h0, "R7 phys zero", got_phys, 32'h0);
        chk(req_count == 1, "R7 one read", 32'(req_count), 32'd1);
        @(negedge clk);
        chk(fault == 1'b0, "R9 fault drops", 32'(fault), 32'h0);
    endtask

    task automatic test_tbl_fault();
        run_walk(32'h0, 32'hF000_5000, 32'h0010_0000, 1'b1, 0);
        chk(got_fault == 1'b1, "R8 fault", 32'(got_fault), 32'h1);
        chk(got_phys == 32'h0, "R8 phys zero", got_phys, 32'h0);
        chk(req_count == 2, "R8 two reads", 32'(req_count), 32'd2);
    endtask

    task automatic test_ignore_start();
        @(negedge clk);
        req_count  = 0;
        rsp_delay  = 2;
        done_cnt   = 0;
        seg_base   = 32'h0000_3000;
        seg_offset = 32'hF000_1234;
        dir_base   = 32'h0010_0000;
        paging_en  = 1'b1;
        start      = 1'b1;
        @(negedge clk);
        seg_offset = 32'h003F_F567;
        paging_en  = 1'b0;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        chk(done_cnt == 1, "R10 single done", 32'(done_cnt), 32'd1);
        chk(phys_addr == 32'h0000_1234, "R10 first result kept", phys_addr, 32'h0000_1234);
        chk(req_log[0] == 32'h0010_0F00, "R10 walk unchanged", req_log[0], 32'h0010_0F00);
    endtask

    initial begin
        mem[32'h0010_0F00] = 32'h0020_0001;
        mem[32'h0020_0010] = 32'h0000_1001;
        mem[32'h0020_0014] = 32'h0000_7000;
        mem[32'h0010_0000] = 32'h0050_0003;
        mem[32'h0050_0FFC] = 32'hABCD_E007;
        mem[32'h0010_0008] = 32'h0060_0000;
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_bypass();
        test_example_walk();
        test_stalled_edges();
        test_dir_fault();
        test_tbl_fault();
        test_example_walk();
        test_ignore_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule